// File: doc/BRIEF.md
# Ethernet destination address filter

This block decides whether an incoming frame should be kept, using the 48-bit destination address at the head of the frame. The six address bytes are fed in one at a time, in wire order. A start flag marks the first byte, and bytes may be spaced by idle cycles. One cycle after the last address byte, the block gives a one-cycle result strobe and an accept flag.

Unicast addresses are compared with a programmed station address. Multicast addresses can be passed wholesale, or filtered through a 64-entry hash table. The table is indexed by the top six bits of the Ethernet CRC-32 of the address. A receive-all mode passes everything, and the all-ones broadcast address is always kept.

The configuration lives in a small set of write-only registers inside the block. Each register is chosen by a select code. Checking the frame check sequence of the whole frame and any buffering of frame data are left to neighbouring logic.

Top module: `addr_filter`

## Requirements
- R1: After reset, `res_valid` and `res_accept` are low, and every configuration register is zero: station address 00:00:00:00:00:00, an empty hash table and all modes off.
- R2: `res_valid` pulses high for exactly one cycle, in the cycle after the clock edge that samples the last address byte. Idle cycles between bytes are allowed. `res_accept` is low whenever `res_valid` is low.
- R3: With receive-all off, a unicast address is accepted only when all six bytes equal the station address. Wire byte k (k = 0..3) is compared with station-low bits [8k+7:8k], and wire bytes 4 and 5 are compared with station-high bits [7:0] and [15:8].
- R4: The address FF:FF:FF:FF:FF:FF is accepted in every mode.
- R5: An address is multicast when bit 0 of its first wire byte is 1. Bit 0 of the other bytes does not affect this classification.
- R6: With hash filtering on, a multicast address is accepted when hash-table bit `idx` is set. `idx` is bits [31:26] of a CRC-32 taken over the six bytes. The CRC uses polynomial 0x04C11DB7, starts from all ones, takes each byte least significant bit first and applies no final inversion. When idx[5] is 1 the bit comes from the hash-high register, otherwise from hash-low; idx[4:0] gives the bit position.
- R7: With pass-all-multicast on, every multicast address is accepted whatever the hash table holds. Unicast handling does not change.
- R8: With receive-all on, every address is accepted.
- R9: With receive-all, pass-all-multicast and hash filtering all off, a non-broadcast multicast address is rejected. The hash table has no effect on unicast addresses.
- R10: A write with `cfg_we` high stores `cfg_wdata` into the register named by `cfg_sel`, and is used from the next cycle on. The select codes are: 0 station low, 1 station high (bits [15:0] only), 2 mode, 3 hash low, 4 hash high. In the mode register, bit 0 is receive-all, bit 1 is pass-all-multicast and bit 2 is hash filtering. The other data bits of station high and mode are ignored.
- R11: A byte with `in_start` high always starts a new address and abandons any partial one. A valid byte that arrives without `in_start` after an address has completed, or before any start, is ignored. An address cut short gives no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Address byte present |
| in_start | input | 1 | Marks the first address byte |
| in_byte | input | 8 | Address byte, wire order |
| res_valid | output | 1 | One-cycle result strobe |
| res_accept | output | 1 | Frame kept when high (qualified by `res_valid`) |

## Verification
The bench builds the block with six address bytes, 32-bit registers and a six-bit hash index. That makes the table exactly the two 32-bit words, so both halves of the table are reached by addresses whose index has bit 5 clear and set. It uses the incremental station compare, where a mismatch in any single byte position shows up at the result. Random idle gaps between bytes, restarts in the middle of an address and bytes with no start stress the counter that places the result strobe.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;

   localparam int CRC_W = 32;

   // mode register layout: bit 0 receive-all, bit 1 pass multicast, bit 2 hash filter
   typedef struct packed {
      logic hash_en;
      logic pass_mcast;
      logic promisc;
   } filt_mode_t;

   localparam int MODE_W = $bits(filt_mode_t);

   // one byte of a CRC shift register, data taken low bit first
   function automatic logic [CRC_W-1:0] crc_feed_byte(input logic [CRC_W-1:0] seed,
                                                      input logic [7:0]       data,
                                                      input logic [CRC_W-1:0] poly);
      logic [CRC_W-1:0] acc;
      logic             fb;
      acc = seed;
      for (int i = 0; i < 8; i++) begin
         fb  = acc[CRC_W-1] ^ data[i];
         acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
      end
      return acc;
   endfunction

endpackage

// File: rtl/addr_filt_regs.sv
module addr_filt_regs
   import addr_filt_pkg::*;
#(
   parameter int REG_W      = 32,
   parameter int ADDR_BYTES = 6,
   parameter int HASH_SIZE  = 64,
   parameter int SEL_W      = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [SEL_W-1:0]        cfg_sel,
   input  logic [REG_W-1:0]        cfg_wdata,
   output logic [8*ADDR_BYTES-1:0] station_o,
   output logic [HASH_SIZE-1:0]    hash_tbl_o,
   output filt_mode_t              mode_o
);

   localparam int STA_BITS   = 8 * ADDR_BYTES;
   localparam int STA_WORDS  = (STA_BITS + REG_W - 1) / REG_W;
   localparam int HASH_WORDS = HASH_SIZE / REG_W;
   localparam int MODE_SEL   = STA_WORDS;
   localparam int HASH_SEL0  = STA_WORDS + 1;

   // station address words, the last one may be narrower than a register
   for (genvar w = 0; w < STA_WORDS; w++) begin : g_sta
      localparam int LO  = w * REG_W;
      localparam int WID = (STA_BITS - LO < REG_W) ? (STA_BITS - LO) : REG_W;
      logic [WID-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (cfg_we && cfg_sel == SEL_W'(w))
            q <= cfg_wdata[WID-1:0];
      end
      assign station_o[LO +: WID] = q;
   end

   // hash table words, word 0 holds the lowest indices
   for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hash
      logic [REG_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (cfg_we && cfg_sel == SEL_W'(HASH_SEL0 + w))
            q <= cfg_wdata;
      end
      assign hash_tbl_o[w*REG_W +: REG_W] = q;
   end

   filt_mode_t mode_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= '0;
      else if (cfg_we && cfg_sel == SEL_W'(MODE_SEL))
         mode_q <= filt_mode_t'(cfg_wdata[MODE_W-1:0]);
   end
   assign mode_o = mode_q;

endmodule

// File: rtl/addr_filt_crc.sv
module addr_filt_crc
   import addr_filt_pkg::*;
#(
   parameter int             HASH_BITS = 6,
   parameter logic [CRC_W-1:0] POLY    = 32'h04C1_1DB7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take_i,
   input  logic                 first_i,
   input  logic [7:0]           byte_i,
   output logic [HASH_BITS-1:0] idx_o
);

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] seed;
   logic [CRC_W-1:0] crc_nxt;

   // a first byte restarts from all ones, whatever is held
   assign seed    = first_i ? '1 : crc_q;
   assign crc_nxt = crc_feed_byte(seed, byte_i, POLY);

   always_ff @(posedge clk) begin
      if (!rst_n)
         crc_q <= '1;
      else if (take_i)
         crc_q <= crc_nxt;
   end

   // index includes the byte presented this cycle
   assign idx_o = crc_nxt[CRC_W-1 -: HASH_BITS];

endmodule

// File: rtl/addr_filt_capture.sv
module addr_filt_capture #(
   parameter int ADDR_BYTES  = 6,
   parameter bit EARLY_MATCH = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_start,
   input  logic [7:0]              in_byte,
   input  logic [8*ADDR_BYTES-1:0] station_i,
   output logic                    take_o,
   output logic                    first_o,
   output logic                    last_o,
   output logic                    mcast_o,
   output logic                    bcast_o,
   output logic                    match_o
);

   localparam int CNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);

   logic             active_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] pos;
   logic             mc_q;
   logic             ones_q;
   logic             ones_run;

   assign pos     = in_start ? '0 : cnt_q;
   assign take_o  = in_valid && (in_start || active_q);
   assign first_o = in_start;
   assign last_o  = take_o && (pos == LAST_POS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (take_o) begin
         active_q <= !last_o;
         cnt_q    <= last_o ? '0 : pos + 1'b1;
      end
   end

   // group bit is the low bit of the first byte on the wire
   always_ff @(posedge clk) begin
      if (!rst_n)
         mc_q <= 1'b0;
      else if (take_o && in_start)
         mc_q <= in_byte[0];
   end
   assign mcast_o = in_start ? in_byte[0] : mc_q;

   // running all-ones test for the broadcast address
   assign ones_run = (in_start ? 1'b1 : ones_q) && (&in_byte);
   always_ff @(posedge clk) begin
      if (!rst_n)
         ones_q <= 1'b0;
      else if (take_o)
         ones_q <= ones_run;
   end
   assign bcast_o = ones_run;

   if (EARLY_MATCH) begin : g_early
      // compare each byte as it arrives, keep one equality bit
      logic       eq_q;
      logic       eq_run;
      logic [7:0] sta_byte;
      assign sta_byte = station_i[8*pos +: 8];
      assign eq_run   = (in_start ? 1'b1 : eq_q) && (in_byte == sta_byte);
      always_ff @(posedge clk) begin
         if (!rst_n)
            eq_q <= 1'b0;
         else if (take_o)
            eq_q <= eq_run;
      end
      assign match_o = eq_run;
   end else begin : g_late
      // hold the leading bytes, compare the whole address at the end
      localparam int HOLD_W = 8 * (ADDR_BYTES - 1);
      logic [HOLD_W-1:0] hold_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            hold_q <= '0;
         else if (take_o && !last_o)
            hold_q <= {in_byte, hold_q[HOLD_W-1:8]};
      end
      assign match_o = ({in_byte, hold_q} == station_i);
   end

endmodule

// File: rtl/addr_filter.sv
module addr_filter
   import addr_filt_pkg::*;
#(
   parameter int               ADDR_BYTES  = 6,
   parameter int               REG_W       = 32,
   parameter int               HASH_BITS   = 6,
   parameter logic [CRC_W-1:0] CRC_POLY    = 32'h04C1_1DB7,
   parameter bit               EARLY_MATCH = 1'b1,
   localparam int HASH_SIZE  = 1 << HASH_BITS,
   localparam int STA_WORDS  = (8 * ADDR_BYTES + REG_W - 1) / REG_W,
   localparam int NUM_REGS   = STA_WORDS + 1 + HASH_SIZE / REG_W,
   localparam int SEL_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             in_valid,
   input  logic             in_start,
   input  logic [7:0]       in_byte,
   output logic             res_valid,
   output logic             res_accept
);

   // elaboration-time parameter checks
   if (ADDR_BYTES < 2) begin : g_bad_bytes
      $error("addr_filter: ADDR_BYTES must be at least 2");
   end
   if (HASH_BITS < 1 || HASH_BITS > CRC_W) begin : g_bad_hash
      $error("addr_filter: HASH_BITS out of range");
   end
   if (HASH_SIZE % REG_W != 0) begin : g_bad_words
      $error("addr_filter: hash table must fill whole registers");
   end
   if (REG_W < MODE_W) begin : g_bad_regw
      $error("addr_filter: REG_W narrower than mode field");
   end

   logic [8*ADDR_BYTES-1:0] station;
   logic [HASH_SIZE-1:0]    hash_tbl;
   filt_mode_t              mode_q;

   addr_filt_regs #(
      .REG_W      (REG_W),
      .ADDR_BYTES (ADDR_BYTES),
      .HASH_SIZE  (HASH_SIZE),
      .SEL_W      (SEL_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .station_o  (station),
      .hash_tbl_o (hash_tbl),
      .mode_o     (mode_q)
   );

   logic cap_take;
   logic cap_first;
   logic last_byte;
   logic cap_mcast;
   logic cap_bcast;
   logic cap_match;

   addr_filt_capture #(
      .ADDR_BYTES  (ADDR_BYTES),
      .EARLY_MATCH (EARLY_MATCH)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_start  (in_start),
      .in_byte   (in_byte),
      .station_i (station),
      .take_o    (cap_take),
      .first_o   (cap_first),
      .last_o    (last_byte),
      .mcast_o   (cap_mcast),
      .bcast_o   (cap_bcast),
      .match_o   (cap_match)
   );

   logic [HASH_BITS-1:0] hash_idx;

   addr_filt_crc #(
      .HASH_BITS (HASH_BITS),
      .POLY      (CRC_POLY)
   ) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (cap_take),
      .first_i (cap_first),
      .byte_i  (in_byte),
      .idx_o   (hash_idx)
   );

   logic promisc_on;
   logic pass_mc_on;
   logic hash_on;
   logic hash_hit;
   logic accept_now;

   assign promisc_on = mode_q.promisc;
   assign pass_mc_on = mode_q.pass_mcast;
   assign hash_on    = mode_q.hash_en;
   assign hash_hit   = hash_tbl[hash_idx];

   // priority: receive-all, broadcast, multicast rules, station compare
   always_comb begin
      if (promisc_on || cap_bcast)
         accept_now = 1'b1;
      else if (cap_mcast)
         accept_now = pass_mc_on || (hash_on && hash_hit);
      else
         accept_now = cap_match;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
      end else begin
         res_valid  <= last_byte;
         res_accept <= last_byte && accept_now;
      end
   end

endmodule

// File: rtl/addr_filt_chk.sv
module addr_filt_chk (
   input logic clk,
   input logic rst_n,
   input logic last_byte,
   input logic mcast_now,
   input logic bcast_now,
   input logic promisc_on,
   input logic pass_mc_on,
   input logic hash_on,
   input logic res_valid,
   input logic res_accept
);

   // R2
   res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R2
   res_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_byte |=> res_valid);

   // R2
   res_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(last_byte));

   // R2
   accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> !res_accept);

   // R8
   promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_byte && promisc_on) |=> res_accept);

   // R4
   bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_byte && bcast_now) |=> res_accept);

   // R7
   pass_mc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_byte && mcast_now && pass_mc_on) |=> res_accept);

   // R9
   mc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_byte && mcast_now && !bcast_now && !promisc_on && !pass_mc_on && !hash_on)
      |=> !res_accept);

endmodule

bind addr_filter addr_filt_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .last_byte  (last_byte),
   .mcast_now  (cap_mcast),
   .bcast_now  (cap_bcast),
   .promisc_on (promisc_on),
   .pass_mc_on (pass_mc_on),
   .hash_on    (hash_on),
   .res_valid  (res_valid),
   .res_accept (res_accept)
);

// File: tb/addr_filter_test.sv
module addr_filter_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [2:0]  cfg_sel;
   logic [31:0] cfg_wdata;
   logic        in_valid;
   logic        in_start;
   logic [7:0]  in_byte;
   logic        res_valid;
   logic        res_accept;

   always #10 clk = ~clk;

   addr_filter uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .in_valid   (in_valid),
      .in_start   (in_start),
      .in_byte    (in_byte),
      .res_valid  (res_valid),
      .res_accept (res_accept)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // bench copy of the configuration, byte k of an address at bits [8k+7:8k]
   logic [47:0] m_sta;
   logic [63:0] m_hash;
   logic [2:0]  m_mode;

   function automatic logic [5:0] ref_idx(input logic [47:0] a);
      logic [31:0] c;
      logic        fb;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++) begin
         fb = c[31] ^ a[i];
         c  = c << 1;
         if (fb) c = c ^ 32'h04C1_1DB7;
      end
      return c[31:26];
   endfunction

   function automatic logic ref_accept(input logic [47:0] a);
      if (m_mode[0]) return 1'b1;
      if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
      if (a[0]) return m_mode[1] | (m_mode[2] & m_hash[ref_idx(a)]);
      return a == m_sta;
   endfunction

   task automatic check(input bit ok, input string req, input string what);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: %s", req, what);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (sel)
         3'd0: m_sta[31:0]   = d;
         3'd1: m_sta[47:32]  = d[15:0];
         3'd2: m_mode        = d[2:0];
         3'd3: m_hash[31:0]  = d;
         3'd4: m_hash[63:32] = d;
         default: ;
      endcase
   endtask

   task automatic send(input logic [47:0] a, input int gmax, input string req);
      logic e, v1, a1, v2;
      bit   early;
      early = 1'b0;
      e = ref_accept(a);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (res_valid) early = 1'b1;
         in_valid = 1'b1; in_start = (k == 0); in_byte = a[8*k +: 8];
         if (k < 5 && gmax > 0) begin
            int g;
            g = $urandom_range(gmax, 0);
            repeat (g) begin
               @(negedge clk);
               if (res_valid) early = 1'b1;
               in_valid = 1'b0; in_start = 1'b0; in_byte = 8'($urandom);
            end
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_start = 1'b0;
      v1 = res_valid; a1 = res_accept;
      @(negedge clk);
      v2 = res_valid;
      check(v1 === 1'b1 && a1 === e && v2 === 1'b0 && !early, req,
            $sformatf("addr=%012h got valid=%b accept=%b next_valid=%b early=%b, expected valid=1 accept=%b next_valid=0 early=0",
                      a, v1, a1, v2, early, e));
   endtask

   // drive n bytes, the first with start unless no_start is set
   task automatic drive_bytes(input int n, input bit no_start);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b1; in_start = (k == 0) && !no_start; in_byte = 8'($urandom);
      end
      @(negedge clk);
      in_valid = 1'b0; in_start = 1'b0;
   endtask

   task automatic expect_quiet(input int cycles, input string req);
      bit seen;
      seen = 1'b0;
      for (int k = 0; k < cycles; k++) begin
         if (res_valid) seen = 1'b1;
         @(negedge clk);
      end
      check(!seen, req, $sformatf("got res_valid pulse=%b, expected none", seen));
   endtask

   function automatic logic [47:0] rand_addr(input bit mcast);
      logic [47:0] a;
      a = {16'($urandom), 32'($urandom)};
      a[0] = mcast;
      return a;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [47:0] a;
      logic [5:0]  ix;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
      in_valid = 1'b0; in_start = 1'b0; in_byte = '0;
      m_sta = '0; m_hash = '0; m_mode = '0;
      repeat (4) @(negedge clk);
      // R1: outputs idle during reset
      check(res_valid === 1'b0 && res_accept === 1'b0, "R1",
            $sformatf("got valid=%b accept=%b, expected 0 0", res_valid, res_accept));
      rst_n = 1'b1;

      // R1: zero station matches the all-zero address, modes off drop multicast
      send(48'h0, 0, "R1");
      send(48'h0000_0000_0001, 0, "R1");

      // R3 / R10: station bytes, upper bits of station high ignored
      wr(3'd0, 32'h3322_1102);
      wr(3'd1, 32'hABCD_5544);
      send(48'h5544_3322_1102, 0, "R3");
      for (int k = 0; k < 6; k++) send(48'h5544_3322_1102 ^ (48'h80 << (8*k)), 0, "R3");

      // R4
      send(48'hFFFF_FFFF_FFFF, 2, "R4");

      // R5: only byte 0 bit 0 marks multicast
      wr(3'd3, 32'hFFFF_FFFF);
      wr(3'd4, 32'hFFFF_FFFF);
      wr(3'd2, 32'hFFFF_FFF4);
      send(48'h0101_0101_0100, 0, "R5");
      send(48'h0101_0101_0101, 0, "R5");

      // R6: one bit set in each half, then all bits but that one
      for (int half = 0; half < 2; half++) begin
         for (int t = 0; t < 1000; t++) begin
            a  = rand_addr(1'b1);
            ix = ref_idx(a);
            if (ix[5] == half[0] && a != 48'hFFFF_FFFF_FFFF) break;
         end
         ix = ref_idx(a);
         wr(3'd3, ix[5] ? 32'h0 : (32'h1 << ix[4:0]));
         wr(3'd4, ix[5] ? (32'h1 << ix[4:0]) : 32'h0);
         send(a, 0, "R6");
         wr(3'd3, ix[5] ? 32'hFFFF_FFFF : ~(32'h1 << ix[4:0]));
         wr(3'd4, ix[5] ? ~(32'h1 << ix[4:0]) : 32'hFFFF_FFFF);
         send(a, 0, "R6");
         // R9: table bit set but hash filtering off
         wr(3'd3, 32'hFFFF_FFFF);
         wr(3'd4, 32'hFFFF_FFFF);
         wr(3'd2, 32'h0);
         send(a, 0, "R9");
         wr(3'd2, 32'h4);
      end

      // R9: full table never admits a foreign unicast
      send(rand_addr(1'b0), 0, "R9");

      // R7
      wr(3'd3, 32'h0);
      wr(3'd4, 32'h0);
      wr(3'd2, 32'h2);
      send(rand_addr(1'b1), 0, "R7");
      send(rand_addr(1'b0), 0, "R7");
      send(48'h5544_3322_1102, 0, "R7");

      // R8
      wr(3'd2, 32'h1);
      send(rand_addr(1'b0), 0, "R8");
      send(rand_addr(1'b1), 1, "R8");

      // R11: abandoned partial address, then a full one gives one result
      drive_bytes(3, 1'b0);
      send(rand_addr(1'b0), 0, "R11");
      drive_bytes(8, 1'b1);
      expect_quiet(6, "R11");
      drive_bytes(4, 1'b0);
      expect_quiet(8, "R11");

      // R2 / R10: random configuration, gaps and addresses
      for (int it = 0; it < 400; it++) begin
         if (it % 20 == 0) begin
            logic [2:0] md;
            md = 3'($urandom);
            if (md[0] && $urandom_range(3, 0) != 0) md[0] = 1'b0;
            wr(3'd0, $urandom);
            wr(3'd1, $urandom);
            wr(3'd3, $urandom);
            wr(3'd4, $urandom);
            wr(3'd2, {29'($urandom), md});
         end
         case ($urandom_range(9, 0))
            0, 1, 2:    a = m_sta;
            3:          a = 48'hFFFF_FFFF_FFFF;
            4, 5, 6, 7: a = rand_addr(1'b1);
            default:    a = rand_addr(1'b0);
         endcase
         send(a, 3, "R2");
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule